// File: doc/BRIEF.md
# Programmable Sum-of-Products Logic Core

This block is a reconfigurable two-level logic core. Twelve dedicated inputs and eight feedback signals are each presented in true and inverted form, which gives forty array lines. Every one of sixty-four product terms ANDs a chosen subset of those lines. A connection map held in on-chip configuration storage decides which line takes part in which term. The terms are split into eight fixed slots of eight. In each slot, seven terms always feed that slot's OR. The eighth, called the spare term, either joins the OR or is routed out as that slot's output enable, chosen per slot by `spare_is_oe`.

The map is stored with one bit per line/term crossing, where 1 means open and 0 means connected. An erased cell therefore leaves its line out of the AND. A term whose cells are all open evaluates true. A term that is connected to both polarities of one signal can never be true. The map is written one term row at a time by a small loader state machine. It takes a start strobe with the term address, then forty serial bits. A single strobe opens every cell at once. All writes are gated by `prog_en`.

The evaluation path from inputs to `or_out`, `oe_out` and `spare_term` has no register in it. Only the configuration storage and the loader are clocked.

Loader states and transitions:
- `LD_IDLE` goes to `LD_ERASE` on `prog_en && erase_req`. Otherwise it goes to `LD_SHIFT` on `prog_en && ld_start`.
- `LD_SHIFT` goes to `LD_COMMIT` when the fortieth bit is accepted. It returns to `LD_IDLE` (abort) if `prog_en` is low.
- `LD_COMMIT` returns to `LD_IDLE` after one cycle, in which the row is written if `prog_en` is high.
- `LD_ERASE` returns to `LD_IDLE` after one cycle, in which every cell is opened if `prog_en` is high.

Top module: `pla_array`

## Requirements
- R1: Line 2i carries signal i and line 2i+1 carries its inverse. Signals 0..11 are `ded_in[0..11]` and signals 12..19 are `fb_in[0..7]`. Term t is the AND of every line whose map bit (row t, bit j = line j) is 0.
- R2: A term whose forty map bits are all 1 (open) evaluates to 1.
- R3: A term connected to both line 2i and line 2i+1 evaluates to 0 for every input value and does not raise its OR.
- R4: Slot s covers terms 8s..8s+7. `or_out[s]` is the OR of terms 8s..8s+6, plus term 8s+7 when `spare_is_oe[s]` is 0.
- R5: When `spare_is_oe[s]` is 1, term 8s+7 is left out of `or_out[s]` and drives `oe_out[s]`. When it is 0, `oe_out[s]` is 1.
- R6: `spare_term[s]` always shows term 8s+7.
- R7: A row load is `ld_start` with `ld_addr` in `LD_IDLE`, followed by forty cycles with `ld_valid` high. The first `ld_bit` sets line 0 and the last sets line 39. Outputs keep the old row until the clock edge after the fortieth bit is accepted, and show the new row from then on.
- R8: With `prog_en` low, no cell changes. Dropping `prog_en` during a load abandons it, and later serial bits without a new start are ignored.
- R9: `erase_req` with `prog_en` in `LD_IDLE` opens every cell on the following clock edge, which makes every `or_out` bit 1.
- R10: After reset every cell is open and the loader is idle.
- R11: A change on `ded_in`, `fb_in` or `spare_is_oe` reaches the outputs with no clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for configuration storage and loader |
| rst_n | input | 1 | Active-low asynchronous reset |
| ded_in | input | 12 | Dedicated logic inputs |
| fb_in | input | 8 | Feedback or pin inputs |
| spare_is_oe | input | 8 | Per-slot routing of the spare term: 1 = enable, 0 = joins OR |
| prog_en | input | 1 | Write permission for the map |
| erase_req | input | 1 | Request to open every cell |
| ld_start | input | 1 | Begins a row load |
| ld_addr | input | 6 | Term row to load |
| ld_valid | input | 1 | Serial bit strobe |
| ld_bit | input | 1 | Serial map bit |
| or_out | output | 8 | Slot OR results |
| oe_out | output | 8 | Slot output enables |
| spare_term | output | 8 | Spare term of each slot |

## Verification
A corrupted cell in the map changes one term, and that change shows up at `or_out` or `spare_term` as soon as an input vector sensitizes that term. The bench therefore compares every output against a software model of the map for many input vectors, and does so after every single row commit. A loader that is off by one bit count or one cycle either shifts the row by one line or moves the visible change by an edge. Both are caught by sampling just before and just after the expected commit edge. A map left half-written after an abort or a blocked erase would show as an output that departs from the unchanged model on the next check.

// File: rtl/pla_pkg.sv
package pla_pkg;
    typedef enum logic [1:0] {
        LD_IDLE   = 2'd0,
        LD_SHIFT  = 2'd1,
        LD_COMMIT = 2'd2,
        LD_ERASE  = 2'd3
    } ld_state_e;
endpackage

// File: rtl/pla_loader.sv
module pla_loader
    import pla_pkg::*;
#(
    parameter int unsigned N_LINE = 40,
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned CNT_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_en,
    input  logic              erase_req,
    input  logic              ld_start,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic              ld_valid,
    input  logic              ld_bit,
    output logic              wr_row_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [N_LINE-1:0] wr_data,
    output logic              erase_all,
    output ld_state_e         state_o
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(N_LINE - 1);

    ld_state_e         state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [ADDR_W-1:0] addr_q;
    logic [N_LINE-1:0] shreg_q;
    logic              take_bit;

    assign take_bit = (state_q == LD_SHIFT) && prog_en && ld_valid;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LD_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LD_IDLE: begin
                if (prog_en && erase_req)     state_d = LD_ERASE;
                else if (prog_en && ld_start) state_d = LD_SHIFT;
            end
            LD_SHIFT: begin
                if (!prog_en)                           state_d = LD_IDLE;
                else if (ld_valid && cnt_q == LAST_BIT) state_d = LD_COMMIT;
            end
            LD_COMMIT: state_d = LD_IDLE;
            LD_ERASE:  state_d = LD_IDLE;
            default:   state_d = LD_IDLE;
        endcase
    end

    // datapath: address latch, bit counter, row shifter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            addr_q  <= '0;
            shreg_q <= '1;
        end else if (state_q == LD_IDLE && prog_en && ld_start && !erase_req) begin
            cnt_q  <= '0;
            addr_q <= ld_addr;
        end else if (take_bit) begin
            cnt_q   <= cnt_q + 1'b1;
            shreg_q <= {ld_bit, shreg_q[N_LINE-1:1]};
        end
    end

    // outputs
    always_comb begin
        wr_row_en = 1'b0;
        erase_all = 1'b0;
        unique case (state_q)
            LD_COMMIT: wr_row_en = prog_en;
            LD_ERASE:  erase_all = prog_en;
            default: ;
        endcase
    end

    assign wr_addr = addr_q;
    assign wr_data = shreg_q;
    assign state_o = state_q;
endmodule

// File: rtl/pla_cfg_mem.sv
module pla_cfg_mem #(
    parameter int unsigned N_LINE = 40,
    parameter int unsigned N_TERM = 64,
    parameter int unsigned ADDR_W = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [N_LINE-1:0]        wr_data,
    input  logic                     erase_all,
    output logic [N_TERM*N_LINE-1:0] cfg_flat
);
    // 1 = open cell, 0 = connected; reset and erase leave every cell open
    for (genvar t = 0; t < N_TERM; t++) begin : g_row
        logic [N_LINE-1:0] row_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                   row_q <= '1;
            else if (erase_all)                           row_q <= '1;
            else if (wr_en && wr_addr == ADDR_W'(t))      row_q <= wr_data;
        end
        assign cfg_flat[t*N_LINE +: N_LINE] = row_q;
    end
endmodule

// File: rtl/pla_terms.sv
module pla_terms #(
    parameter int unsigned N_DED  = 12,
    parameter int unsigned N_FB   = 8,
    parameter int unsigned N_TERM = 64,
    localparam int unsigned N_SIG  = N_DED + N_FB,
    localparam int unsigned N_LINE = 2 * N_SIG
) (
    input  logic [N_DED-1:0]         ded_in,
    input  logic [N_FB-1:0]          fb_in,
    input  logic [N_TERM*N_LINE-1:0] cfg_flat,
    output logic [N_TERM-1:0]        terms
);
    logic [N_SIG-1:0]  sigs;
    logic [N_LINE-1:0] lines;

    assign sigs = {fb_in, ded_in};

    for (genvar i = 0; i < N_SIG; i++) begin : g_line
        assign lines[2*i]   = sigs[i];
        assign lines[2*i+1] = ~sigs[i];
    end

    // an open cell (1) forces its line out of the AND
    for (genvar t = 0; t < N_TERM; t++) begin : g_term
        assign terms[t] = &(cfg_flat[t*N_LINE +: N_LINE] | lines);
    end
endmodule

// File: rtl/pla_or_route.sv
module pla_or_route #(
    parameter int unsigned N_SLOT = 8,
    parameter int unsigned TPS    = 8,
    localparam int unsigned N_TERM = N_SLOT * TPS
) (
    input  logic [N_TERM-1:0] terms,
    input  logic [N_SLOT-1:0] spare_is_oe,
    output logic [N_SLOT-1:0] or_out,
    output logic [N_SLOT-1:0] oe_out,
    output logic [N_SLOT-1:0] spare_term
);
    for (genvar s = 0; s < N_SLOT; s++) begin : g_slot
        logic [TPS-1:0] grp;
        logic           sum_fixed;
        assign grp           = terms[s*TPS +: TPS];
        assign sum_fixed     = |grp[TPS-2:0];
        assign spare_term[s] = grp[TPS-1];
        assign or_out[s]     = sum_fixed | (grp[TPS-1] & ~spare_is_oe[s]);
        assign oe_out[s]     = spare_is_oe[s] ? grp[TPS-1] : 1'b1;
    end
endmodule

// File: rtl/pla_array.sv
module pla_array
    import pla_pkg::*;
#(
    parameter int unsigned N_DED     = 12,
    parameter int unsigned N_FB      = 8,
    parameter int unsigned N_SLOT    = 8,
    parameter int unsigned SUM_TERMS = 7,
    localparam int unsigned TPS    = SUM_TERMS + 1,
    localparam int unsigned N_TERM = N_SLOT * TPS,
    localparam int unsigned N_LINE = 2 * (N_DED + N_FB),
    localparam int unsigned ADDR_W = $clog2(N_TERM),
    localparam int unsigned CNT_W  = $clog2(N_LINE + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_DED-1:0]  ded_in,
    input  logic [N_FB-1:0]   fb_in,
    input  logic [N_SLOT-1:0] spare_is_oe,
    input  logic              prog_en,
    input  logic              erase_req,
    input  logic              ld_start,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic              ld_valid,
    input  logic              ld_bit,
    output logic [N_SLOT-1:0] or_out,
    output logic [N_SLOT-1:0] oe_out,
    output logic [N_SLOT-1:0] spare_term
);
    logic                     wr_row_en;
    logic [ADDR_W-1:0]        wr_addr;
    logic [N_LINE-1:0]        wr_data;
    logic                     erase_all;
    ld_state_e                ld_state;
    logic [N_TERM*N_LINE-1:0] cfg_flat;
    logic [N_TERM-1:0]        terms;

    pla_loader #(.N_LINE(N_LINE), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_loader (
        .clk(clk), .rst_n(rst_n), .prog_en(prog_en), .erase_req(erase_req),
        .ld_start(ld_start), .ld_addr(ld_addr), .ld_valid(ld_valid), .ld_bit(ld_bit),
        .wr_row_en(wr_row_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .erase_all(erase_all), .state_o(ld_state)
    );

    pla_cfg_mem #(.N_LINE(N_LINE), .N_TERM(N_TERM), .ADDR_W(ADDR_W)) u_mem (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_row_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .erase_all(erase_all), .cfg_flat(cfg_flat)
    );

    pla_terms #(.N_DED(N_DED), .N_FB(N_FB), .N_TERM(N_TERM)) u_terms (
        .ded_in(ded_in), .fb_in(fb_in), .cfg_flat(cfg_flat), .terms(terms)
    );

    pla_or_route #(.N_SLOT(N_SLOT), .TPS(TPS)) u_route (
        .terms(terms), .spare_is_oe(spare_is_oe), .or_out(or_out),
        .oe_out(oe_out), .spare_term(spare_term)
    );
endmodule

// File: rtl/pla_array_chk.sv
module pla_array_chk
    import pla_pkg::*;
#(
    parameter int unsigned N_SLOT = 8,
    parameter int unsigned N_TERM = 64,
    parameter int unsigned N_LINE = 40
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     prog_en,
    input logic                     ld_valid,
    input logic [N_SLOT-1:0]        spare_is_oe,
    input logic [N_SLOT-1:0]        or_out,
    input logic [N_SLOT-1:0]        oe_out,
    input logic [N_SLOT-1:0]        spare_term,
    input ld_state_e                ld_state,
    input logic [N_TERM*N_LINE-1:0] cfg_flat
);
    int unsigned bits_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                      bits_seen <= 0;
        else if (ld_state != LD_SHIFT)                   bits_seen <= 0;
        else if (prog_en && ld_valid)                    bits_seen <= bits_seen + 1;
    end

    p_map_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_en |=> $stable(cfg_flat));

    p_erase_opens_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_state == LD_ERASE && prog_en) |=> (&or_out));

    p_enable_tied_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((oe_out | spare_is_oe) == '1));

    p_enable_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (((oe_out ^ spare_term) & spare_is_oe) == '0));

    p_spare_in_sum_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((spare_term & ~spare_is_oe & ~or_out) == '0));

    p_full_row_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_state == LD_COMMIT) |-> (bits_seen == N_LINE));
endmodule

bind pla_array pla_array_chk #(.N_SLOT(N_SLOT), .N_TERM(N_TERM), .N_LINE(N_LINE)) u_chk (
    .clk(clk), .rst_n(rst_n), .prog_en(prog_en), .ld_valid(ld_valid),
    .spare_is_oe(spare_is_oe), .or_out(or_out), .oe_out(oe_out),
    .spare_term(spare_term), .ld_state(ld_state), .cfg_flat(cfg_flat)
);

// File: tb/sim_pla_array.sv
`timescale 1ns/1ps
module sim_pla_array;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] ded_in = '0;
    logic [7:0]  fb_in = '0;
    logic [7:0]  spare_is_oe = '0;
    logic        prog_en = 1'b0;
    logic        erase_req = 1'b0;
    logic        ld_start = 1'b0;
    logic [5:0]  ld_addr = '0;
    logic        ld_valid = 1'b0;
    logic        ld_bit = 1'b0;
    logic [7:0]  or_out, oe_out, spare_term;

    int n_chk = 0;
    int n_fail = 0;
    logic [39:0] mdl [64];

    always #5 clk = ~clk;

    pla_array u0 (
        .clk(clk), .rst_n(rst_n), .ded_in(ded_in), .fb_in(fb_in),
        .spare_is_oe(spare_is_oe), .prog_en(prog_en), .erase_req(erase_req),
        .ld_start(ld_start), .ld_addr(ld_addr), .ld_valid(ld_valid), .ld_bit(ld_bit),
        .or_out(or_out), .oe_out(oe_out), .spare_term(spare_term)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model(output logic [7:0] e_or, output logic [7:0] e_oe, output logic [7:0] e_sp);
        logic [39:0] ln;
        logic [63:0] tv;
        logic [19:0] sg;
        sg = {fb_in, ded_in};
        for (int i = 0; i < 20; i++) begin
            ln[2*i]   = sg[i];
            ln[2*i+1] = ~sg[i];
        end
        for (int t = 0; t < 64; t++) begin
            tv[t] = 1'b1;
            for (int j = 0; j < 40; j++)
                if (!mdl[t][j] && !ln[j]) tv[t] = 1'b0;
        end
        for (int s = 0; s < 8; s++) begin
            e_sp[s] = tv[8*s+7];
            e_or[s] = 1'b0;
            for (int k = 0; k < 7; k++) e_or[s] |= tv[8*s+k];
            if (!spare_is_oe[s]) e_or[s] |= tv[8*s+7];
            e_oe[s] = spare_is_oe[s] ? tv[8*s+7] : 1'b1;
        end
    endtask

    task automatic chk_model(input string tag);
        logic [7:0] eo, ee, es;
        model(eo, ee, es);
        chk(or_out == eo, {tag, " or_out"}, 64'(or_out), 64'(eo));
        chk(oe_out == ee, {tag, " oe_out"}, 64'(oe_out), 64'(ee));
        chk(spare_term == es, {tag, " spare_term"}, 64'(spare_term), 64'(es));
    endtask

    // R7: old row visible until the edge after the 40th bit, new row after it
    task automatic load_row(input int a, input logic [39:0] r);
        @(negedge clk);
        prog_en = 1'b1; ld_start = 1'b1; ld_addr = 6'(a);
        @(negedge clk);
        ld_start = 1'b0;
        for (int j = 0; j < 40; j++) begin
            ld_valid = 1'b1; ld_bit = r[j];
            @(negedge clk);
        end
        ld_valid = 1'b0;
        chk_model("R7 before commit");
        @(negedge clk);
        mdl[a] = r;
        chk_model("R7 after commit");
    endtask

    function automatic logic [39:0] open_except(input int a, input int b);
        logic [39:0] r;
        r = '1;
        r[a] = 1'b0;
        if (b >= 0) r[b] = 1'b0;
        return r;
    endfunction

    task automatic t_reset();
        chk(or_out == 8'hFF, "R10 R2 or_out after reset", 64'(or_out), 64'hFF);
        chk(oe_out == 8'hFF, "R10 oe_out after reset", 64'(oe_out), 64'hFF);
        chk(spare_term == 8'hFF, "R10 spare_term after reset", 64'(spare_term), 64'hFF);
    endtask

    task automatic t_slot0_logic();
        // terms 1..7 of slot 0 tied to ded_in[0] and its inverse (R3)
        for (int k = 1; k < 8; k++) load_row(k, open_except(0, 1));
        // term 0 = ded_in[0] & ~fb_in[3]  (signal 15 -> inverse line 31) R1
        ded_in = '0;
        load_row(0, open_except(0, 31));
        for (int v = 0; v < 4; v++) begin
            @(negedge clk);
            ded_in[0] = v[0]; fb_in[3] = v[1];
            #1;
            chk(or_out[0] == (v[0] & ~v[1]), "R1 term literal", 64'(or_out[0]), 64'(v[0] & ~v[1]));
            chk(spare_term[0] == 1'b0, "R3 complementary pair false", 64'(spare_term[0]), 64'h0);
        end
        chk_model("R4 slot0 model");
    endtask

    task automatic t_spare_route();
        ded_in = '0; fb_in = '0;
        load_row(7, open_except(2, -1)); // spare of slot 0 = ded_in[1]
        @(negedge clk); ded_in[1] = 1'b1; spare_is_oe[0] = 1'b0; #1;
        chk(or_out[0] == 1'b1, "R4 spare joins OR", 64'(or_out[0]), 64'h1);
        chk(oe_out[0] == 1'b1, "R5 enable high in sum mode", 64'(oe_out[0]), 64'h1);
        spare_is_oe[0] = 1'b1; #1;
        chk(or_out[0] == 1'b0, "R5 spare removed from OR", 64'(or_out[0]), 64'h0);
        chk(oe_out[0] == 1'b1, "R5 enable follows spare", 64'(oe_out[0]), 64'h1);
        ded_in[1] = 1'b0; #1;
        chk(oe_out[0] == 1'b0, "R5 enable follows spare low", 64'(oe_out[0]), 64'h0);
        chk(spare_term[0] == 1'b0, "R6 spare shown", 64'(spare_term[0]), 64'h0);
        spare_is_oe[0] = 1'b0; #1;
        chk_model("R11 R6 routing model");
    endtask

    task automatic t_guard();
        ded_in = '0; fb_in = '0; spare_is_oe = '0;
        // full load with prog_en low must leave the map alone
        @(negedge clk);
        prog_en = 1'b0; ld_start = 1'b1; ld_addr = 6'd0;
        @(negedge clk); ld_start = 1'b0;
        for (int j = 0; j < 42; j++) begin
            ld_valid = 1'b1; ld_bit = 1'b1;
            @(negedge clk);
        end
        ld_valid = 1'b0;
        chk(or_out[0] == 1'b0, "R8 load without enable ignored", 64'(or_out[0]), 64'h0);
        // abort: drop prog_en midway, then keep streaming bits
        prog_en = 1'b1; ld_start = 1'b1;
        @(negedge clk); ld_start = 1'b0;
        for (int j = 0; j < 20; j++) begin
            ld_valid = 1'b1; ld_bit = 1'b1;
            @(negedge clk);
        end
        prog_en = 1'b0;
        @(negedge clk);
        prog_en = 1'b1;
        for (int j = 0; j < 25; j++) @(negedge clk);
        ld_valid = 1'b0;
        @(negedge clk); @(negedge clk);
        chk(or_out[0] == 1'b0, "R8 aborted load ignored", 64'(or_out[0]), 64'h0);
        chk_model("R8 map unchanged");
        // erase without enable
        prog_en = 1'b0; erase_req = 1'b1;
        @(negedge clk); @(negedge clk);
        erase_req = 1'b0;
        chk(or_out[0] == 1'b0, "R8 erase without enable ignored", 64'(or_out[0]), 64'h0);
    endtask

    task automatic t_erase();
        ded_in = '0; fb_in = '0; spare_is_oe = '0;
        @(negedge clk);
        prog_en = 1'b1; erase_req = 1'b1;
        @(negedge clk);
        erase_req = 1'b0;
        chk(or_out[0] == 1'b0, "R9 erase not yet applied", 64'(or_out[0]), 64'h0);
        @(negedge clk);
        for (int t = 0; t < 64; t++) mdl[t] = '1;
        chk(or_out == 8'hFF, "R9 R2 erase opens all", 64'(or_out), 64'hFF);
        chk_model("R9 erased model");
    endtask

    task automatic t_random();
        for (int t = 0; t < 64; t++) begin
            logic [39:0] r;
            r = '1;
            for (int c = 0; c < 3; c++) r[$urandom_range(39, 0)] = 1'b0;
            load_row(t, r);
        end
        for (int v = 0; v < 40; v++) begin
            @(negedge clk);
            ded_in = 12'($urandom); fb_in = 8'($urandom); spare_is_oe = 8'($urandom);
            #1;
            chk_model("R1 R4 R5 R6 R11 random map");
        end
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int t = 0; t < 64; t++) mdl[t] = '1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_slot0_logic();
        t_spare_route();
        t_guard();
        t_erase();
        t_random();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule